// File: doc/BRIEF.md
# Overvoltage Staggered Shunt Ladder

This block protects a directly connected power bus from overvoltage by diverting solar array power away from it in small steps. It receives a stream of digitised bus-voltage codes and compares each accepted code against a ladder of eight rising thresholds. The seven lower rungs each shunt one digital array segment. The top rung forces the pulse-width-modulated segment into full shunt. As the voltage climbs, segments are shed one rung at a time. As it falls, they are returned in the reverse order. Each rung has a hysteresis band, so a voltage that hovers near a threshold does not make its segment chatter.

A plain command input picks one of two threshold sets. The nominal set places its first rung at 34.0 V and spaces the rungs 0.125 V apart. The lowered set moves the whole ladder down by a fixed offset. With a bus-voltage scale of 12.5 mV per count, the default parameters give these thresholds in counts: 2720 + 10·k for rung k in nominal mode, and 112 counts lower in lowered mode. Every accepted sample is evaluated in full. With no battery present, the array can therefore be shed or reconnected as fast as samples arrive. The always-connected diode segment is outside this block and is never shunted.

The sample input is a valid/ready stream. The block applies no back-pressure. `sample_ready` is low while reset is asserted and stays high at all other times. A code is consumed on every rising clock edge where `sample_valid` is high and reset is released.

Top module: `ovp_shunt_ladder`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `shunt_en` is 8'h00 and `shed_count` is 0. `sample_ready` is 0 while reset is asserted.
- R2: In nominal mode (`lowered` = 0), rung 0 (`shunt_en` bit 0) is asserted when an accepted code is at least 2720, and it is not asserted by a code of 2719 from an unshed state.
- R3: Digital rung k (k = 0..6, `shunt_en` bit k) has threshold 2720 + 10·k counts in nominal mode.
- R4: The PWM full-shunt rung is `shunt_en` bit 7, with threshold 2790 in nominal mode. This is one step above the last digital rung.
- R5: With `lowered` = 1, every threshold is 112 counts lower: the first rung is at 2608 and the PWM rung at 2678. `lowered` is sampled only together with an accepted code.
- R6: A shed rung with threshold T is released only when an accepted code is below T − 4. Codes from T − 4 up to T − 1 leave it shed.
- R7: `shunt_en` is always a thermometer code filled from bit 0 upwards. Shedding takes the lowest free rung first, and restoring releases the most recently shed rung first. `shed_count` equals the number of set bits.
- R8: Outputs change one clock edge after an accepted code. While `sample_valid` is low, `shunt_en` and `shed_count` hold their values.
- R9: A single accepted code can shed or restore several rungs at once. The result depends only on the code, the mode and the previous state.
- R10: Once reset is released, `sample_ready` is 1 on every cycle (no back-pressure).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_code | input | 12 | Digitised bus-voltage code |
| sample_valid | input | 1 | Code on `sample_code` is offered |
| sample_ready | output | 1 | Block accepts a code this cycle |
| lowered | input | 1 | 0 selects the nominal thresholds, 1 the lowered set |
| shunt_en | output | 8 | Bits 0..6 shunt digital segments; bit 7 forces the PWM segment fully shunted |
| shed_count | output | 4 | Number of rungs currently shed |

## Verification
The ladder is driven by a rising ramp that lands exactly on and one code below rung thresholds, which separates correct thresholds from off-by-one comparisons. It is then driven by falling codes placed at the edge of the hysteresis band and one count past it. Large jumps up and down show whether several rungs move together or one at a time. A mode switch in both directions checks that the offset is applied to the whole ladder and takes effect only with a new sample. Idle cycles carrying changed data and a changed mode confirm that nothing moves without a valid strobe.

// File: rtl/ovp_ladder_pkg.sv
package ovp_ladder_pkg;
  typedef enum logic {
    THR_NOMINAL = 1'b0,
    THR_LOWERED = 1'b1
  } thr_set_e;

  // threshold of rung k for a given set, in counts
  function automatic int rung_threshold(input int base, input int step,
                                        input int offset, input int k,
                                        input thr_set_e set);
    int t;
    t = base + k * step;
    if (set == THR_LOWERED) t = t - offset;
    return t;
  endfunction
endpackage

// File: rtl/ovp_rung_bank.sv
module ovp_rung_bank
  import ovp_ladder_pkg::*;
#(
  parameter int SAMPLE_W   = 12,
  parameter int N_RUNGS    = 8,
  parameter int BASE_CODE  = 2720,
  parameter int STEP_CODE  = 10,
  parameter int LOW_OFFSET = 112,
  parameter int HYST_CODE  = 4
) (
  input  logic [SAMPLE_W-1:0] code,
  input  thr_set_e            set_sel,
  output logic [N_RUNGS-1:0]  trip_vec,
  output logic [N_RUNGS-1:0]  keep_vec
);
  for (genvar k = 0; k < N_RUNGS; k++) begin : g_rung
    localparam int THR_NOM = rung_threshold(BASE_CODE, STEP_CODE, LOW_OFFSET, k, THR_NOMINAL);
    localparam int THR_LOW = rung_threshold(BASE_CODE, STEP_CODE, LOW_OFFSET, k, THR_LOWERED);
    int thr_sel;
    int code_i;
    always_comb begin
      thr_sel     = (set_sel == THR_LOWERED) ? THR_LOW : THR_NOM;
      code_i      = int'(code);
      trip_vec[k] = (code_i >= thr_sel);
      keep_vec[k] = (code_i + HYST_CODE >= thr_sel);
    end
  end
endmodule

// File: rtl/ovp_level_ctrl.sv
module ovp_level_ctrl #(
  parameter int N_RUNGS = 8,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [N_RUNGS-1:0] trip_vec,
  input  logic [N_RUNGS-1:0] keep_vec,
  output logic [CNT_W-1:0]   level
);
  logic [CNT_W-1:0] up_cnt;
  logic [CNT_W-1:0] keep_cnt;
  logic [CNT_W-1:0] level_nx;

  always_comb begin
    up_cnt   = '0;
    keep_cnt = '0;
    for (int k = 0; k < N_RUNGS; k++) begin
      up_cnt   = up_cnt + {{(CNT_W-1){1'b0}}, trip_vec[k]};
      keep_cnt = keep_cnt + {{(CNT_W-1){1'b0}}, keep_vec[k]};
    end
    level_nx = level;
    if (keep_cnt < level_nx) level_nx = keep_cnt;
    if (up_cnt > level_nx)   level_nx = up_cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    level <= '0;
    else if (take) level <= level_nx;
  end

  // R6: a code below every release point empties the ladder
  p_release_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && keep_vec == '0) |=> (level == '0));

  // R9: a code above every threshold fills the ladder in one step
  p_fill_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && &trip_vec) |=> (level == CNT_W'(N_RUNGS)));
endmodule

// File: rtl/ovp_therm_out.sv
module ovp_therm_out #(
  parameter int N_RUNGS = 8,
  parameter int CNT_W   = 4
) (
  input  logic [CNT_W-1:0]   level,
  output logic [N_RUNGS-1:0] enables
);
  for (genvar k = 0; k < N_RUNGS; k++) begin : g_bit
    assign enables[k] = (level > CNT_W'(k));
  end
endmodule

// File: rtl/ovp_shunt_ladder.sv
module ovp_shunt_ladder
  import ovp_ladder_pkg::*;
#(
  parameter int SAMPLE_W   = 12,
  parameter int N_DIGITAL  = 7,
  parameter int BASE_CODE  = 2720,
  parameter int STEP_CODE  = 10,
  parameter int LOW_OFFSET = 112,
  parameter int HYST_CODE  = 4,
  localparam int N_RUNGS   = N_DIGITAL + 1,
  localparam int CNT_W     = $clog2(N_RUNGS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sample_code,
  input  logic                sample_valid,
  output logic                sample_ready,
  input  logic                lowered,
  output logic [N_RUNGS-1:0]  shunt_en,
  output logic [CNT_W-1:0]    shed_count
);
  logic [N_RUNGS-1:0] trip_vec;
  logic [N_RUNGS-1:0] keep_vec;
  logic [CNT_W-1:0]   level;
  logic               take;
  thr_set_e           set_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) sample_ready <= 1'b0;
    else        sample_ready <= 1'b1;
  end

  assign take    = sample_valid && sample_ready;
  assign set_sel = lowered ? THR_LOWERED : THR_NOMINAL;

  ovp_rung_bank #(
    .SAMPLE_W(SAMPLE_W), .N_RUNGS(N_RUNGS), .BASE_CODE(BASE_CODE),
    .STEP_CODE(STEP_CODE), .LOW_OFFSET(LOW_OFFSET), .HYST_CODE(HYST_CODE)
  ) u_bank (
    .code(sample_code), .set_sel(set_sel),
    .trip_vec(trip_vec), .keep_vec(keep_vec)
  );

  ovp_level_ctrl #(.N_RUNGS(N_RUNGS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .take(take),
    .trip_vec(trip_vec), .keep_vec(keep_vec), .level(level)
  );

  ovp_therm_out #(.N_RUNGS(N_RUNGS), .CNT_W(CNT_W)) u_out (
    .level(level), .enables(shunt_en)
  );

  assign shed_count = level;

  // R8: nothing moves without an accepted code
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(shunt_en) && $stable(shed_count)));

  // R7: enables form a thermometer from bit 0
  p_thermo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((shunt_en & (shunt_en + 1'b1)) == '0));

  // R7: count agrees with the enables
  p_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(shunt_en) == int'(shed_count)));

  // R2: a nominal code at the first threshold sheds rung 0
  p_first_rung_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !lowered && int'(sample_code) >= BASE_CODE) |=> shunt_en[0]);

  // R10: no back-pressure once out of reset
  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> sample_ready);
endmodule

// File: tb/ovp_shunt_ladder_bench.sv
module ovp_shunt_ladder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] sample_code = '0;
  logic        sample_valid = 1'b0;
  logic        sample_ready;
  logic        lowered = 1'b0;
  logic [7:0]  shunt_en;
  logic [3:0]  shed_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovp_shunt_ladder u_ovp_shunt_ladder (
    .clk(clk), .rst_n(rst_n), .sample_code(sample_code),
    .sample_valid(sample_valid), .sample_ready(sample_ready),
    .lowered(lowered), .shunt_en(shunt_en), .shed_count(shed_count)
  );

  // {lowered, code, expected enables}; walked in order, state carries over
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 12'd2000, 8'h00},  // R2 far below
    {1'b0, 12'd2719, 8'h00},  // R2 one below
    {1'b0, 12'd2720, 8'h01},  // R2 at threshold
    {1'b0, 12'd2735, 8'h03},  // R3
    {1'b0, 12'd2789, 8'h7F},  // R3 all digital
    {1'b0, 12'd2790, 8'hFF},  // R4 PWM rung
    {1'b0, 12'd2786, 8'hFF},  // R6 edge of band
    {1'b0, 12'd2785, 8'h7F},  // R6 released
    {1'b0, 12'd2716, 8'h01},  // R7/R9 highest released first
    {1'b0, 12'd2715, 8'h00},  // R6
    {1'b0, 12'd2800, 8'hFF},  // R9 jump up
    {1'b0, 12'd2000, 8'h00},  // R9 jump down
    {1'b1, 12'd2607, 8'h00},  // R5 below lowered
    {1'b1, 12'd2608, 8'h01},  // R5 lowered first
    {1'b1, 12'd2678, 8'hFF},  // R5 lowered PWM
    {1'b0, 12'd2700, 8'h00},  // R5 back to nominal
    {1'b0, 12'd2745, 8'h07},  // R3
    {1'b0, 12'd2739, 8'h07}   // R6 inside band
  };

  task automatic check(input string req, input logic [7:0] exp_en);
    checks++;
    if (shunt_en !== exp_en || int'(shed_count) != $countones(exp_en)) begin
      errors++;
      $display("FAIL %s: shunt_en=%h count=%0d expected %h count=%0d",
               req, shunt_en, shed_count, exp_en, $countones(exp_en));
    end
  endtask

  task automatic send(input logic low, input logic [11:0] code);
    @(negedge clk);
    lowered = low;
    sample_code = code;
    sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 8'h00);
    checks++;
    if (sample_ready !== 1'b0) begin
      errors++;
      $display("FAIL R1: sample_ready=%b expected 0", sample_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 8'h00);
    checks++;
    if (sample_ready !== 1'b1) begin
      errors++;
      $display("FAIL R10: sample_ready=%b expected 1", sample_ready);
    end

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][20], VEC[i][19:8]);
      check($sformatf("R3/R6 vector %0d", i), VEC[i][7:0]);
    end

    // R8: idle cycles with new data and mode do nothing
    @(negedge clk);
    sample_code = 12'd2000;
    lowered = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 idle", 8'h07);
    sample_code = 12'd4000;
    @(negedge clk);
    check("R8 idle high", 8'h07);

    // R5: mode latched only with a sample
    send(1'b1, 12'd2640);
    check("R5 lowered", 8'h0F);
    send(1'b0, 12'd2640);
    check("R5 nominal", 8'h00);

    // R8: one-edge latency
    @(negedge clk);
    lowered = 1'b0;
    sample_code = 12'd2760;
    sample_valid = 1'b1;
    @(posedge clk);
    #1;
    check("R8 latency", 8'h1F);
    @(negedge clk);
    sample_valid = 1'b0;

    // R10: ready held across activity
    checks++;
    if (sample_ready !== 1'b1) begin
      errors++;
      $display("FAIL R10: sample_ready=%b expected 1", sample_ready);
    end

    // R1: reset clears a full ladder
    send(1'b0, 12'd3000);
    check("R9 full", 8'hFF);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset", 8'h00);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule